// File: doc/BRIEF.md
# Synthesizer serial register loader

This block receives configuration for a frequency synthesizer over a three-wire serial port: a serial clock, a serial data line and a load strobe. All three pins are asynchronous to the system clock. They are synchronized into the system clock domain, and their edges are detected there. On each rising serial-clock edge, one data bit enters a 24-bit shift register, most significant bit first. On a rising strobe edge, the accumulated word is committed to one of four parallel registers. The register is chosen by the word's own two lowest bits.

Each commit raises a one-cycle update pulse for the register that was written. A write to the divider-N register also raises a band-selection start pulse. Bit 22 of that register is brought out directly as the divide-by-2 output enable. The fourth register is reserved for factory test. Writes to it are stored, but they set a sticky warning. A second flag reports whether, after reset, the registers were first loaded in the required order: divider-R, then control, then divider-N.

Top module: `synth_serial_loader`

## Requirements
- R1: Each rising edge of `ser_sck` shifts the synchronized `ser_sdi` into the 24-bit shift register, MSB first, so the last bit sent becomes bit 0. A pin change takes effect in the shift register at the third rising `sys_clk` edge after it.
- R2: The third rising `sys_clk` edge after `ser_strobe` rises copies the shift register into the register selected by bits [1:0]: 00 → `ctrl_word`, 01 → `rdiv_word`, 10 → `ndiv_word`, 11 → `test_word`.
- R3: Registers not selected keep their value. Shifting without a strobe rise changes no output register.
- R4: `upd[i]` is high for exactly the one cycle in which the register with address i takes its new value. It is low otherwise, and at most one bit is high at a time.
- R5: `band_start` pulses for one cycle with each write to the divider-N register (address 10), and only then.
- R6: `div2_en` equals bit 22 of `ndiv_word`.
- R7: A write to address 11 stores the word in `test_word` and sets `test_warn`, which stays high until reset. It leaves the other three registers unchanged.
- R8: `order_ok` rises with the divider-N write when the first three writes after reset were addresses 01, 00, 10 in that order. Any other first three writes keep it low until reset. Once high, it stays high.
- R9: Under reset all registers, pulses and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sck | input | 1 | Serial clock, asynchronous |
| ser_sdi | input | 1 | Serial data, asynchronous |
| ser_strobe | input | 1 | Load strobe, asynchronous |
| ctrl_word | output | 24 | Control register (address 00) |
| rdiv_word | output | 24 | Divider-R register (address 01) |
| ndiv_word | output | 24 | Divider-N register (address 10) |
| test_word | output | 24 | Factory test register (address 11) |
| upd | output | 4 | One-cycle update pulse per register, indexed by address |
| band_start | output | 1 | One-cycle band-selection start pulse |
| div2_en | output | 1 | Divide-by-2 output enable |
| test_warn | output | 1 | Sticky flag: test register was written |
| order_ok | output | 1 | Power-up write order was followed |

## Verification
The assertions assume that every pin level is held for at least two system clock cycles. They also assume that a strobe rise never falls in the same synchronized cycle as a serial-clock rise, so that a commit sees a settled word. The stimulus holds each serial-clock phase and each strobe phase for three to four cycles. It raises the strobe only after the serial clock has finished its last rising edge. A cycle-accurate behavioural model is compared on every cycle outside reset. The sequences cover the correct power-up order, a wrong order, a test-register write, a stray shift with no strobe, and both values of the divide-by-2 bit.

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int DIV2_BIT    = 22
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              ser_sck,
  input  logic              ser_sdi,
  input  logic              ser_strobe,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] rdiv_word,
  output logic [WORD_W-1:0] ndiv_word,
  output logic [WORD_W-1:0] test_word,
  output logic [3:0]        upd,
  output logic              band_start,
  output logic              div2_en,
  output logic              test_warn,
  output logic              order_ok
);
  localparam int HIST = SYNC_STAGES + 1;

  logic [HIST-1:0]        sck_q, stb_q;
  logic [SYNC_STAGES-1:0] sdi_q;
  logic [WORD_W-1:0]      shreg;
  logic [1:0]             stage;
  logic                   seq_bad;
  logic [1:0]             want;

  wire sck_rise = sck_q[HIST-2] & ~sck_q[HIST-1];
  wire stb_rise = stb_q[HIST-2] & ~stb_q[HIST-1];
  wire [1:0] addr = shreg[1:0];

  assign band_start = upd[2];
  assign div2_en    = ndiv_word[DIV2_BIT];
  assign want       = (stage == 2'd0) ? 2'b01 : (stage == 2'd1) ? 2'b00 : 2'b10;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      stb_q <= '0;
      sdi_q <= '0;
      shreg <= '0;
    end else begin
      sck_q <= {sck_q[HIST-2:0], ser_sck};
      stb_q <= {stb_q[HIST-2:0], ser_strobe};
      sdi_q <= {sdi_q[SYNC_STAGES-2:0], ser_sdi};
      if (sck_rise) shreg <= {shreg[WORD_W-2:0], sdi_q[SYNC_STAGES-1]};
    end
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= '0;
      rdiv_word <= '0;
      ndiv_word <= '0;
      test_word <= '0;
      upd       <= '0;
      test_warn <= 1'b0;
    end else begin
      upd <= stb_rise ? (4'b0001 << addr) : 4'b0000;
      if (stb_rise) begin
        case (addr)
          2'b00: ctrl_word <= shreg;
          2'b01: rdiv_word <= shreg;
          2'b10: ndiv_word <= shreg;
          default: begin
            test_word <= shreg;
            test_warn <= 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= '0;
      seq_bad  <= 1'b0;
      order_ok <= 1'b0;
    end else if (stb_rise && !seq_bad && !order_ok) begin
      if (addr != want)       seq_bad  <= 1'b1;
      else if (stage == 2'd2) order_ok <= 1'b1;
      else                    stage    <= stage + 2'd1;
    end
  end

  p_upd_onehot_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $onehot0(upd));

  p_quiet_without_strobe_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !stb_rise |=> ($stable(ctrl_word) && $stable(rdiv_word) && $stable(ndiv_word)
                   && $stable(test_word) && upd == 4'b0000));

  p_test_isolated_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    upd[3] |-> ($stable(ctrl_word) && $stable(rdiv_word) && $stable(ndiv_word) && test_warn));

  p_warn_sticky_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    test_warn |=> test_warn);

  p_order_sticky_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    order_ok |=> order_ok);

  p_order_rises_on_n_r8: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(order_ok) |-> band_start);
endmodule

// File: tb/test_synth_serial_loader.sv
module test_synth_serial_loader;
  logic sys_clk = 1'b0, rst_n = 1'b0;
  logic ser_sck = 1'b0, ser_sdi = 1'b0, ser_strobe = 1'b0;
  logic [23:0] ctrl_word, rdiv_word, ndiv_word, test_word;
  logic [3:0] upd;
  logic band_start, div2_en, test_warn, order_ok;

  int checks = 0, failures = 0, band_count = 0;
  bit done = 0;

  always #2.5 sys_clk = ~sys_clk;

  synth_serial_loader i_synth_serial_loader (
    .sys_clk(sys_clk), .rst_n(rst_n), .ser_sck(ser_sck), .ser_sdi(ser_sdi),
    .ser_strobe(ser_strobe), .ctrl_word(ctrl_word), .rdiv_word(rdiv_word),
    .ndiv_word(ndiv_word), .test_word(test_word), .upd(upd),
    .band_start(band_start), .div2_en(div2_en), .test_warn(test_warn),
    .order_ok(order_ok));

  // behavioural reference: pin history queues, newest sample first
  bit q_sck[$], q_sdi[$], q_stb[$];
  logic [23:0] m_sh, m_reg[4];
  logic [3:0] m_upd;
  bit m_warn, m_ok, m_bad;
  int m_writes;

  always @(posedge sys_clk) begin
    if (!rst_n) begin
      q_sck = {0, 0, 0}; q_sdi = {0, 0, 0}; q_stb = {0, 0, 0};
      m_sh = 0; m_upd = 0; m_warn = 0; m_ok = 0; m_bad = 0; m_writes = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
    end else begin
      bit srise, trise;
      int a;
      srise = q_sck[1] && !q_sck[2];
      trise = q_stb[1] && !q_stb[2];
      m_upd = 0;
      if (trise) begin
        a = int'(m_sh[1:0]);
        m_reg[a] = m_sh;
        m_upd[a] = 1'b1;
        if (a == 3) m_warn = 1;
        if (!m_ok && !m_bad) begin
          if (a != ((m_writes == 0) ? 1 : (m_writes == 1) ? 0 : 2)) m_bad = 1;
          else begin
            m_writes++;
            if (m_writes == 3) m_ok = 1;
          end
        end
      end
      if (srise) m_sh = {m_sh[22:0], q_sdi[1]};
      q_sck.push_front(ser_sck); q_sdi.push_front(ser_sdi); q_stb.push_front(ser_strobe);
      void'(q_sck.pop_back()); void'(q_sdi.pop_back()); void'(q_stb.pop_back());
    end
  end

  task automatic cmp(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge sys_clk) begin
    if (rst_n && !done) begin
      cmp("R2 ctrl_word", ctrl_word, m_reg[0]);
      cmp("R2 rdiv_word", rdiv_word, m_reg[1]);
      cmp("R2 ndiv_word", ndiv_word, m_reg[2]);
      cmp("R7 test_word", test_word, m_reg[3]);
      cmp("R4 upd", 24'(upd), 24'(m_upd));
      cmp("R5 band_start", 24'(band_start), 24'(m_upd[2]));
      cmp("R6 div2_en", 24'(div2_en), 24'(m_reg[2][22]));
      cmp("R7 test_warn", 24'(test_warn), 24'(m_warn));
      cmp("R8 order_ok", 24'(order_ok), 24'(m_ok));
      if (band_start) band_count++;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic shift_word(logic [23:0] w);
    for (int b = 23; b >= 0; b--) begin
      ser_sdi = w[b]; ser_sck = 1'b0; wait_cyc(3);
      ser_sck = 1'b1; wait_cyc(3);
    end
    ser_sck = 1'b0; wait_cyc(3);
  endtask

  task automatic send_word(logic [23:0] w);
    shift_word(w);
    ser_strobe = 1'b1; wait_cyc(4);
    ser_strobe = 1'b0; wait_cyc(4);
  endtask

  task automatic do_reset();
    @(negedge sys_clk); #1 rst_n = 1'b0;
    wait_cyc(1);
    cmp("R9 reset ctrl_word", ctrl_word, 0);
    cmp("R9 reset flags", 24'({upd, band_start, test_warn, order_ok}), 0);
    wait_cyc(3);
    #1 rst_n = 1'b1;
    wait_cyc(1);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog expired act=running exp=finished");
    failures++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    cmp("R9 all regs zero", rdiv_word | ndiv_word | test_word, 0);
    send_word(24'hABCDE1);                         // address 01
    cmp("R1 R2 rdiv value", rdiv_word, 24'hABCDE1);
    cmp("R8 not yet complete", 24'(order_ok), 0);
    send_word(24'h123450);                         // address 00
    cmp("R2 ctrl value", ctrl_word, 24'h123450);
    cmp("R3 rdiv kept", rdiv_word, 24'hABCDE1);
    send_word(24'h400002);                         // address 10, divide-by-2 bit set
    cmp("R2 ndiv value", ndiv_word, 24'h400002);
    cmp("R6 div2 on", 24'(div2_en), 1);
    cmp("R8 order followed", 24'(order_ok), 1);
    cmp("R5 one band pulse", 24'(band_count), 1);
    shift_word(24'h5A5A5A);
    wait_cyc(6);
    cmp("R3 stray shift ctrl", ctrl_word, 24'h123450);
    cmp("R3 stray shift ndiv", ndiv_word, 24'h400002);
    send_word(24'h00FF03);                         // address 11
    cmp("R7 test stored", test_word, 24'h00FF03);
    cmp("R7 warn set", 24'(test_warn), 1);
    cmp("R7 ctrl untouched", ctrl_word, 24'h123450);
    send_word(24'h000006);                         // address 10, divide-by-2 clear
    cmp("R6 div2 off", 24'(div2_en), 0);
    cmp("R5 two band pulses", 24'(band_count), 2);
    cmp("R7 warn sticky", 24'(test_warn), 1);

    do_reset();
    cmp("R9 warn cleared", 24'(test_warn), 0);
    send_word(24'h0000AA);                         // address 10 first: wrong order
    send_word(24'hFFFFF1);
    send_word(24'hFFFFF0);
    send_word(24'h7FFFFE);
    cmp("R8 wrong order", 24'(order_ok), 0);
    cmp("R1 MSB-first ctrl", ctrl_word, 24'hFFFFF0);
    cmp("R6 div2 from ndiv", 24'(div2_en), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule